// File: doc/BRIEF.md
# Nybble Register Window Command Processor

This block runs commands that a host posts through a one-word mailbox against a private file of 256 four-bit registers. The host writes a 7-bit word: a 3-bit opcode in bits 6:4 and a 4-bit argument in bits 3:0. It then writes 0 to a semaphore bit to ask for execution. The semaphore reads 0 while the processor works. When the command is finished, the processor sets the semaphore back to 1, and any 4-bit answer is then readable in the low half of the mailbox.

An 8-bit pointer selects the register that is used. The host can load the pointer one half at a time, and it can read or write a register with an automatic step of the pointer afterwards. One opcode carries a sub-command in its argument. The sub-commands copy a time value from a clock block into registers 0 to 6, push those registers back to the clock block, answer a status query, or fire a tone request.

The number of cycles a command takes is set at run time, so host software has to poll the semaphore.

Top module: `nyb_cmd_engine`

## Requirements
- R1: After reset, the semaphore reads 1, the mailbox reads 0x00, and `tone_go` and `time_load` are both low.
- R2: Reading the mailbox returns the last accepted opcode in bits 6:4 and the result nybble in bits 3:0, never the argument. A mailbox write on its own starts nothing: the semaphore stays 1 and the result does not change.
- R3: Writing 0 to the semaphore while it reads 1 starts a command. The semaphore then reads 0 for exactly max(L, N) cycles and returns to 1.
  - L is `lat_cfg`, raised to 2 when it is below 2.
  - N is 8 for the time copy-in, 9 for the time push-out, 3 for the tone request, and 2 for every other command.
  - Writing 1 to the semaphore has no effect.
- R4: Opcode 1 puts register[pointer] into the result and then increments the pointer.
- R5: Opcode 3 stores the argument into register[pointer] and then increments the pointer. The pointer wraps from 0xFF to 0x00.
- R6: Opcode 4 replaces pointer bits 3:0 with the argument. Opcode 5 replaces pointer bits 7:4 with the argument.
- R7: Opcode 6 with argument 0x0 copies `time_now` into registers 0 to 6. Register k receives `time_now[4k+3:4k]`.
- R8: Opcode 6 with argument 0x1 pulses `time_load` for exactly one cycle. During that pulse, `time_load_val[4k+3:4k]` equals register k for k = 0 to 6.
- R9: Opcode 6 with argument 0x2 sets the result to 0x1.
- R10: Opcode 6 with argument 0xE pulses `tone_go` for one cycle with `tone_sel` equal to register 0x26 bits 1:0. The pulse happens only when register 0x27 equals exactly 0x1; otherwise no pulse occurs.
- R11: The following commands change no register, no pointer and no result, but still complete through the semaphore:
  - opcodes 0, 2 and 7;
  - opcode 6 with any argument other than 0x0, 0x1, 0x2 and 0xE.
- R12: While the semaphore reads 0, mailbox writes and semaphore writes are ignored.
- R13: A mailbox write and a semaphore clear in the same cycle execute the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mbox_wr | input | 1 | Mailbox write strobe |
| mbox_wdata | input | 7 | Opcode (6:4) and argument (3:0) |
| mbox_rdata | output | 7 | Stored opcode (6:4) and result (3:0) |
| sem_wr | input | 1 | Semaphore write strobe |
| sem_wdata | input | 1 | Semaphore value; 0 requests execution |
| sem_rdata | output | 1 | 1 when idle, 0 while executing |
| lat_cfg | input | LAT_W | Minimum command duration in cycles |
| time_now | input | 4*CLK_NYB | Current time from the clock block |
| time_load | output | 1 | One-cycle strobe to load a new time |
| time_load_val | output | 4*CLK_NYB | Time value to load |
| tone_go | output | 1 | One-cycle tone request |
| tone_sel | output | 2 | Tone number for the request |

## Verification
Two pairs of events can fall on one clock edge. The first pair is a mailbox write and a semaphore clear. The bench drives both strobes in the same cycle and checks that the opcode read back and the result belong to the new word. The second pair is the tone pulse, which lands on the same edge that releases the semaphore when the latency is at its minimum. The bench checks for the pulse after the semaphore returns, and it also fires writes into a running command to confirm they are dropped.

// File: rtl/nyb_pkg.sv
package nyb_pkg;
  localparam int NYB_W  = 4;
  localparam int ADDR_W = 2 * NYB_W;
  localparam int TONE_W = 2;

  typedef enum logic [2:0] {
    OP_NOP0  = 3'd0,
    OP_RDINC = 3'd1,
    OP_NOP2  = 3'd2,
    OP_WRINC = 3'd3,
    OP_PTRLO = 3'd4,
    OP_PTRHI = 3'd5,
    OP_EXT   = 3'd6,
    OP_NOP7  = 3'd7
  } op_e;

  localparam logic [NYB_W-1:0] SUB_GRAB = 4'h0;
  localparam logic [NYB_W-1:0] SUB_PUSH = 4'h1;
  localparam logic [NYB_W-1:0] SUB_STAT = 4'h2;
  localparam logic [NYB_W-1:0] SUB_TONE = 4'hE;

  localparam logic [ADDR_W-1:0] TONE_NUM_REG = 8'h26;
  localparam logic [ADDR_W-1:0] TONE_ARM_REG = 8'h27;

  // Minimum number of busy steps a command needs for its own work.
  function automatic int steps_needed(op_e op, logic [NYB_W-1:0] arg, int clk_nyb);
    if (op == OP_EXT && arg == SUB_GRAB) return clk_nyb + 1;
    if (op == OP_EXT && arg == SUB_PUSH) return clk_nyb + 2;
    if (op == OP_EXT && arg == SUB_TONE) return 3;
    return 2;
  endfunction
endpackage

// File: rtl/nyb_regfile.sv
module nyb_regfile #(
  parameter int AW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nyb_exec.sv
module nyb_exec
  import nyb_pkg::*;
#(
  parameter int CLK_NYB = 7,
  parameter int LAT_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  op_e                    op,
  input  logic [NYB_W-1:0]       arg,
  input  logic [LAT_W-1:0]       lat_cfg,
  input  logic [4*CLK_NYB-1:0]   time_now,
  output logic                   busy,
  output logic [NYB_W-1:0]       result,
  output logic                   tone_go,
  output logic [TONE_W-1:0]      tone_sel,
  output logic                   time_load,
  output logic [4*CLK_NYB-1:0]   time_load_val
);
  localparam int TW = 4 * CLK_NYB;
  localparam int SW = ((LAT_W > 5) ? LAT_W : 5) + 1;

  logic [SW-1:0]     step;
  logic [ADDR_W-1:0] ptr;
  logic [TW-1:0]     snap;
  logic [TW-1:0]     acc;

  logic              rf_we;
  logic [ADDR_W-1:0] rf_waddr;
  logic [NYB_W-1:0]  rf_wdata;
  logic [ADDR_W-1:0] rf_raddr;
  logic [NYB_W-1:0]  rf_rdata;

  int  need;
  int  lat_eff;
  int  stp;
  logic last_step;
  logic is_grab, is_push, is_tone, is_stat;

  always_comb begin
    stp       = int'(step);
    need      = steps_needed(op, arg, CLK_NYB);
    lat_eff   = (int'(lat_cfg) < 2) ? 2 : int'(lat_cfg);
    last_step = (stp + 1 >= need) && (stp + 1 >= lat_eff);
    is_grab   = (op == OP_EXT) && (arg == SUB_GRAB);
    is_push   = (op == OP_EXT) && (arg == SUB_PUSH);
    is_tone   = (op == OP_EXT) && (arg == SUB_TONE);
    is_stat   = (op == OP_EXT) && (arg == SUB_STAT);
  end

  // Register file port selection per command and step.
  always_comb begin
    rf_raddr = ptr;
    if (is_push)      rf_raddr = ADDR_W'(step);
    else if (is_tone) rf_raddr = (stp == 0) ? TONE_NUM_REG : TONE_ARM_REG;

    rf_we    = 1'b0;
    rf_waddr = ptr;
    rf_wdata = arg;
    if (busy && op == OP_WRINC && stp == 0) begin
      rf_we = 1'b1;
    end else if (busy && is_grab && stp >= 1 && stp <= CLK_NYB) begin
      rf_we    = 1'b1;
      rf_waddr = ADDR_W'(stp - 1);
      rf_wdata = snap[NYB_W-1:0];
    end
  end

  nyb_regfile #(.AW(ADDR_W), .DW(NYB_W)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      step      <= '0;
      ptr       <= '0;
      result    <= '0;
      tone_go   <= 1'b0;
      tone_sel  <= '0;
      time_load <= 1'b0;
      snap      <= '0;
      acc       <= '0;
    end else begin
      tone_go   <= 1'b0;
      time_load <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          step <= '0;
        end
      end else begin
        step <= step + 1'b1;
        if (last_step) busy <= 1'b0;
        unique case (op)
          OP_RDINC: if (stp == 1) begin
            result <= rf_rdata;
            ptr    <= ptr + 1'b1;
          end
          OP_WRINC: if (stp == 0) ptr <= ptr + 1'b1;
          OP_PTRLO: if (stp == 0) ptr[NYB_W-1:0] <= arg;
          OP_PTRHI: if (stp == 0) ptr[ADDR_W-1:NYB_W] <= arg;
          OP_EXT: begin
            if (is_grab) begin
              if (stp == 0) snap <= time_now;
              else if (stp <= CLK_NYB) snap <= snap >> NYB_W;
            end
            if (is_push) begin
              if (stp >= 1 && stp <= CLK_NYB) acc <= {rf_rdata, acc[TW-1:NYB_W]};
              else if (stp == CLK_NYB + 1) time_load <= 1'b1;
            end
            if (is_stat && stp == 0) result <= 4'h1;
            if (is_tone) begin
              if (stp == 1) tone_sel <= rf_rdata[TONE_W-1:0];
              else if (stp == 2 && rf_rdata == 4'h1) tone_go <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign time_load_val = acc;
endmodule

// File: rtl/nyb_cmd_engine.sv
module nyb_cmd_engine
  import nyb_pkg::*;
#(
  parameter int CLK_NYB = 7,
  parameter int LAT_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mbox_wr,
  input  logic [6:0]           mbox_wdata,
  output logic [6:0]           mbox_rdata,
  input  logic                 sem_wr,
  input  logic                 sem_wdata,
  output logic                 sem_rdata,
  input  logic [LAT_W-1:0]     lat_cfg,
  input  logic [4*CLK_NYB-1:0] time_now,
  output logic                 time_load,
  output logic [4*CLK_NYB-1:0] time_load_val,
  output logic                 tone_go,
  output logic [1:0]           tone_sel
);
  op_e              cur_op;
  logic [NYB_W-1:0] cur_arg;
  logic [NYB_W-1:0] result;
  logic             busy;
  logic             start;

  assign start = sem_wr && !sem_wdata && !busy;

  // Mailbox is frozen while a command runs; a same-cycle write feeds the start.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_op  <= OP_NOP0;
      cur_arg <= '0;
    end else if (mbox_wr && !busy) begin
      cur_op  <= op_e'(mbox_wdata[6:4]);
      cur_arg <= mbox_wdata[3:0];
    end
  end

  nyb_exec #(.CLK_NYB(CLK_NYB), .LAT_W(LAT_W)) u_exec (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .op            (cur_op),
    .arg           (cur_arg),
    .lat_cfg       (lat_cfg),
    .time_now      (time_now),
    .busy          (busy),
    .result        (result),
    .tone_go       (tone_go),
    .tone_sel      (tone_sel),
    .time_load     (time_load),
    .time_load_val (time_load_val)
  );

  assign mbox_rdata = {cur_op, result};
  assign sem_rdata  = ~busy;
endmodule

// File: rtl/nyb_cmd_engine_chk.sv
module nyb_cmd_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       sem_rdata,
  input logic [6:0] mbox_rdata,
  input logic       tone_go,
  input logic       time_load
);
  // R3: a started command stays busy for at least two cycles
  a_r3_min_two_cycles: assert property (@(posedge clk) disable iff (rst)
    $fell(sem_rdata) |=> !sem_rdata);

  // R12: stored opcode cannot change across a busy interval
  a_r12_opcode_frozen: assert property (@(posedge clk) disable iff (rst)
    (!sem_rdata && $past(!sem_rdata)) |-> $stable(mbox_rdata[6:4]));

  // R2: result does not move while idle
  a_r2_result_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (sem_rdata && $past(sem_rdata)) |-> $stable(mbox_rdata[3:0]));

  // R10: tone request is a single-cycle pulse issued from a busy interval
  a_r10_tone_single: assert property (@(posedge clk) disable iff (rst)
    tone_go |=> !tone_go);
  a_r10_tone_from_busy: assert property (@(posedge clk) disable iff (rst)
    tone_go |-> $past(!sem_rdata));

  // R8: load strobe is a single-cycle pulse issued from a busy interval
  a_r8_load_single: assert property (@(posedge clk) disable iff (rst)
    time_load |=> !time_load);
  a_r8_load_from_busy: assert property (@(posedge clk) disable iff (rst)
    time_load |-> $past(!sem_rdata));
endmodule

bind nyb_cmd_engine nyb_cmd_engine_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sem_rdata  (sem_rdata),
  .mbox_rdata (mbox_rdata),
  .tone_go    (tone_go),
  .time_load  (time_load)
);

// File: tb/tb_nyb_cmd_engine.sv
`timescale 1ns/1ps
module tb_nyb_cmd_engine;
  localparam int CLK_NYB = 7;
  localparam int LAT_W   = 8;
  localparam int TW      = 4 * CLK_NYB;

  logic          clk = 0;
  logic          rst = 1;
  logic          mbox_wr = 0;
  logic [6:0]    mbox_wdata = '0;
  logic [6:0]    mbox_rdata;
  logic          sem_wr = 0;
  logic          sem_wdata = 1;
  logic          sem_rdata;
  logic [LAT_W-1:0] lat_cfg = '0;
  logic [TW-1:0] time_now = '0;
  logic          time_load;
  logic [TW-1:0] time_load_val;
  logic          tone_go;
  logic [1:0]    tone_sel;

  always #2 clk = ~clk;

  nyb_cmd_engine #(.CLK_NYB(CLK_NYB), .LAT_W(LAT_W)) dut (.*);

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [3:0] m_mem [256];
  logic [7:0] m_ptr = 0;
  logic [3:0] m_res = 0;
  logic [2:0] m_op  = 0;

  // Pulse monitor
  int          tone_cnt = 0;
  logic [1:0]  tone_seen = 0;
  int          load_cnt = 0;
  logic [TW-1:0] load_seen = 0;
  always @(negedge clk) begin
    if (tone_go)   begin tone_cnt++; tone_seen = tone_sel; end
    if (time_load) begin load_cnt++; load_seen = time_load_val; end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_dur(input logic [6:0] w, input int lat);
    int n = 2;
    int l = (lat < 2) ? 2 : lat;
    if (w[6:4] == 3'd6 && w[3:0] == 4'h0) n = CLK_NYB + 1;
    if (w[6:4] == 3'd6 && w[3:0] == 4'h1) n = CLK_NYB + 2;
    if (w[6:4] == 3'd6 && w[3:0] == 4'hE) n = 3;
    return (n > l) ? n : l;
  endfunction

  function automatic string tag_of(input logic [6:0] w);
    case (w[6:4])
      3'd1: return "R4";
      3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      3'd6: case (w[3:0])
              4'h0: return "R7";
              4'h1: return "R8";
              4'h2: return "R9";
              4'hE: return "R10";
              default: return "R11";
            endcase
      default: return "R11";
    endcase
  endfunction

  task automatic run_cmd(input logic [6:0] w, input int lat, input bit together);
    int n;
    int ed;
    int exp_tone;
    int exp_load;
    logic [1:0] exp_sel;
    logic [TW-1:0] exp_val;
    string tg;
    ed = exp_dur(w, lat);
    tg = tag_of(w);
    exp_tone = 0; exp_load = 0; exp_sel = 0; exp_val = 0;
    @(negedge clk);
    lat_cfg = LAT_W'(lat);
    mbox_wr = 1; mbox_wdata = w;
    if (together) begin
      sem_wr = 1; sem_wdata = 0;
    end else begin
      @(negedge clk);
      mbox_wr = 0; sem_wr = 1; sem_wdata = 0;
    end
    tone_cnt = 0; load_cnt = 0;
    @(negedge clk);
    mbox_wr = 0; sem_wr = 0; sem_wdata = 1;
    n = 0;
    while (sem_rdata === 1'b0 && n < 200) begin n++; @(negedge clk); end
    #1;
    // model update
    m_op = w[6:4];
    case (w[6:4])
      3'd1: begin m_res = m_mem[m_ptr]; m_ptr = m_ptr + 1; end
      3'd3: begin m_mem[m_ptr] = w[3:0]; m_ptr = m_ptr + 1; end
      3'd4: m_ptr[3:0] = w[3:0];
      3'd5: m_ptr[7:4] = w[3:0];
      3'd6: case (w[3:0])
              4'h0: for (int k = 0; k < CLK_NYB; k++) m_mem[k] = time_now[4*k +: 4];
              4'h1: begin
                exp_load = 1;
                for (int k = 0; k < CLK_NYB; k++) exp_val[4*k +: 4] = m_mem[k];
              end
              4'h2: m_res = 4'h1;
              4'hE: if (m_mem[8'h27] == 4'h1) begin exp_tone = 1; exp_sel = m_mem[8'h26][1:0]; end
              default: ;
            endcase
      default: ;
    endcase
    chk(n == ed, "R3 busy length", n, ed);
    chk(mbox_rdata == {m_op, m_res}, together ? "R13 same-cycle word" : tg, mbox_rdata, {m_op, m_res});
    chk(tone_cnt == exp_tone, "R10 tone pulses", tone_cnt, exp_tone);
    if (exp_tone == 1) chk(tone_seen == exp_sel, "R10 tone number", tone_seen, exp_sel);
    chk(load_cnt == exp_load, "R8 load pulses", load_cnt, exp_load);
    if (exp_load == 1) chk(load_seen == exp_val, "R8 load value", load_seen, exp_val);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    run_cmd({3'd4, p[3:0]}, 0, 0);
    run_cmd({3'd5, p[7:4]}, 0, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(sem_rdata == 1'b1, "R1 semaphore", sem_rdata, 1);
    chk(mbox_rdata == 7'h00, "R1 mailbox", mbox_rdata, 0);
    chk(tone_go == 0 && time_load == 0, "R1 strobes", {tone_go, time_load}, 0);

    // R2 mailbox write alone starts nothing
    mbox_wr = 1; mbox_wdata = 7'h35;
    @(negedge clk); mbox_wr = 0;
    repeat (4) @(negedge clk);
    chk(sem_rdata == 1'b1, "R2 no start from mailbox", sem_rdata, 1);
    chk(mbox_rdata == 7'h30, "R2 readback shows result", mbox_rdata, 7'h30);

    // R3 writing 1 to semaphore does nothing
    sem_wr = 1; sem_wdata = 1;
    @(negedge clk); sem_wr = 0;
    chk(sem_rdata == 1'b1, "R3 write of one ignored", sem_rdata, 1);
    repeat (3) @(negedge clk);
    chk(mbox_rdata == 7'h30, "R3 no execution", mbox_rdata, 7'h30);
    m_op = 3'd3;

    // Fill register file with known values
    set_ptr(8'h00);
    for (int i = 0; i < 256; i++) run_cmd({3'd3, 4'($urandom)}, 0, 0);
    chk(m_ptr == 8'h00, "R5 pointer wrapped after fill", m_ptr, 0);
    run_cmd({3'd1, 4'h0}, 0, 0);  // R4 reads reg 0

    // R5 wrap at 0xFF
    set_ptr(8'hFF);
    run_cmd(7'h39, 3, 0);
    run_cmd(7'h10, 2, 0);

    // R10 tone armed and disarmed
    set_ptr(8'h26);
    run_cmd(7'h33, 0, 0);
    run_cmd(7'h31, 0, 0);
    run_cmd(7'h6E, 0, 0);
    run_cmd(7'h6E, 6, 1);
    set_ptr(8'h27);
    run_cmd(7'h32, 0, 0);
    run_cmd(7'h6E, 0, 0);

    // R7 / R8 time in and out
    time_now = 28'h1234567;
    run_cmd(7'h60, 0, 0);
    time_now = 28'h0ABCDEF;
    run_cmd(7'h61, 12, 0);
    set_ptr(8'h00);
    for (int k = 0; k < CLK_NYB; k++) run_cmd(7'h10, 0, 0);

    // R9 status, R11 inert commands
    run_cmd(7'h62, 0, 0);
    run_cmd(7'h0A, 0, 0);
    run_cmd(7'h2F, 5, 0);
    run_cmd(7'h75, 0, 0);
    run_cmd(7'h63, 0, 0);
    run_cmd(7'h6F, 4, 0);

    // R13 same-cycle write and start
    run_cmd(7'h14, 0, 1);

    // R12 writes during a running command
    @(negedge clk);
    lat_cfg = 8'd10;
    mbox_wr = 1; mbox_wdata = 7'h47;
    @(negedge clk);
    mbox_wr = 0; sem_wr = 1; sem_wdata = 0;
    @(negedge clk);
    sem_wr = 0; sem_wdata = 1;
    @(negedge clk);
    mbox_wr = 1; mbox_wdata = 7'h7F; sem_wr = 1; sem_wdata = 0;
    @(negedge clk);
    mbox_wr = 0; sem_wr = 0; sem_wdata = 1;
    n = 2;
    while (sem_rdata === 1'b0 && n < 200) begin n++; @(negedge clk); end
    m_op = 3'd4; m_ptr[3:0] = 4'h7;
    chk(n == 10, "R12 busy length unaffected", n, 10);
    chk(mbox_rdata[6:4] == 3'd4, "R12 mailbox write dropped", mbox_rdata[6:4], 4);
    repeat (4) @(negedge clk);
    chk(sem_rdata == 1'b1, "R12 semaphore clear dropped", sem_rdata, 1);
    run_cmd(7'h10, 0, 0);

    // Random mix
    for (int i = 0; i < 500; i++) begin
      logic [6:0] w;
      int r;
      r = int'($urandom % 16);
      w = 7'($urandom);
      if (r < 4)       w[6:4] = 3'd1;
      else if (r < 7)  w[6:4] = 3'd3;
      else if (r < 9)  w[6:4] = (r == 7) ? 3'd4 : 3'd5;
      else if (r < 13) begin
        w[6:4] = 3'd6;
        case ($urandom % 5)
          0: w[3:0] = 4'h0;
          1: w[3:0] = 4'h1;
          2: w[3:0] = 4'h2;
          3: w[3:0] = 4'hE;
          default: ;
        endcase
      end
      time_now = TW'($urandom);
      run_cmd(w, int'($urandom % 12), bit'($urandom % 2));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule